// File: doc/BRIEF.md
# Spread-spectrum fractional-N divide ratio controller

This block supplies the divide value a PLL feedback divider uses on every reference clock cycle. The nominal ratio is the integer M = 2·N + A + 1. A first-order sigma-delta accumulator dithers that integer by whole steps so that the long-run average carries a fraction in 1/64 steps. The block runs in one of three modes. In integer mode the ratio is fixed. In fractional mode a constant 6-bit offset sets the fraction. In spread-spectrum mode a stored table of sample magnitudes adds a slow triangular or downward-only modulation on top of the offset.

Configuration is captured in a shadow copy only when the load strobe is high. The shadow copy is promoted to the active copy at the end of the modulation period in progress, so a period never mixes two settings. The modulation period is a whole number of reference cycles, and it is also used in integer and fractional modes. A one-cycle start pulse marks the first divide value of each period, which lets downstream logic or a bench integrate one period. The accumulator restarts at zero on each period, so every period produces the same divide total.

Top module: `ssc_frac_div`

## Requirements
- R1: When the active step field `tssc` is 0, every divide value equals 2·N + A + 1 and `err_o` is 0, whatever the settings of `sd_en_i` and `offset_i`.
- R2: When `tssc` > 0, `sd_en_i` = 0 and `offset_i` ≠ 0, each divide value is M or M+1, and the total over a period of P cycles is M·P + floor(offset·P/64).
- R3: When `tssc` > 0, `sd_en_i` = 0 and `offset_i` = 0, the block sets `err_o` to 1 and holds every divide value at M.
- R4: A period lasts 4·S·T reference cycles, with T = `tssc` + 2 and S = 2·`nssc`. A `nssc` of 0 acts as 1. `period_start_o` is high on the first divide value of each period.
- R5: When `tssc` > 0 and `sd_en_i` = 1, the sample index walks up through 0..S−1 and then back down, and each sample is held for T cycles. With `center_i` = 1, samples are added in the first half of the period and subtracted in the second half, so the period total is M·P + floor(offset·P/64).
- R6: With `center_i` = 0 in spread-spectrum mode, every sample is subtracted. The period total is M·P + floor((offset·P − 4·T·Σ sample[i] for i<S)/64).
- R7: Sample i occupies bits [7i+6:7i] of `table_i` as an unsigned magnitude. When `offset_i` is 0, a magnitude above 63 is used as 63. Otherwise it is used as given.
- R8: All settings, the sample table included, are captured only on a cycle with `load_i` high. They take effect at the start of the period after the one in progress. Inputs that change without a load have no effect.
- R9: While `rst_ni` is low, `div_o`, `err_o` and `period_start_o` are 0. After reset the active settings are all zero, which gives integer mode with M = 1 and a 16-cycle period.
- R10: The sigma-delta accumulator restarts at 0 at each period start, so the first divide value of a fractional-mode period is exactly M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Captures all setting inputs into the shadow copy |
| n_i | input | 12 | N field of the integer ratio |
| a_i | input | 4 | A field of the integer ratio |
| offset_i | input | 6 | Fixed fraction in 1/64 units |
| tssc_i | input | 4 | Step field; the step period is this value + 2 |
| nssc_i | input | 4 | Sample-count field; the count is twice this value |
| sd_en_i | input | 1 | Selects spread-spectrum modulation |
| center_i | input | 1 | 1: centre spread (sign flips at half period); 0: down spread |
| table_i | input | 224 | 32 sample magnitudes of 7 bits each |
| div_o | output | 14 | Divide value for this reference cycle |
| err_o | output | 1 | Illegal combination of settings active |
| period_start_o | output | 1 | First divide value of a modulation period |

## Verification
The bench runs the block through a chain of settings: integer mode with a small ratio and with the largest ratio, the spread enable set while the step field is zero, a fractional offset, the illegal zero-offset case, centre spread with and without an offset, and down spread with magnitudes above 63 both clamped and unclamped. For each period it compares the divide total, the period length and the error flag. The exact total separates a wrong fraction, a wrong sample walk or sign, a missing clamp and an accumulator that is not restarted. The length separates errors in the step and count encodings. Each new setting is loaded in the middle of a period and the inputs are scrambled straight afterwards, which shows whether a change leaks into the period in progress.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_FRAC = 2'd1,
    MODE_SSC  = 2'd2,
    MODE_BAD  = 2'd3
  } mode_e;

  function automatic mode_e pick_mode(input logic step_nz, input logic sd_en, input logic off_nz);
    if (!step_nz)   return MODE_INT;
    else if (sd_en) return MODE_SSC;
    else if (off_nz) return MODE_FRAC;
    else            return MODE_BAD;
  endfunction
endpackage

// File: rtl/ssc_cfg_regs.sv
module ssc_cfg_regs #(
  parameter int CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             wrap_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CFG_W-1:0] act_o
);
  logic [CFG_W-1:0] shadow_q, act_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (load_i) shadow_q <= cfg_i;
      if (wrap_i && pend_q) act_q <= shadow_q;
      if (load_i)      pend_q <= 1'b1;
      else if (wrap_i) pend_q <= 1'b0;
    end
  end

  assign act_o = act_q;

  // R8
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_q));
endmodule

// File: rtl/ssc_profile_seq.sv
module ssc_profile_seq #(
  parameter int T_W    = 4,
  parameter int NS_W   = 4,
  parameter int SAMP_W = 7,
  parameter int FRAC_W = 6,
  localparam int IDX_W = NS_W + 1,
  localparam int TBL_D = 2 ** IDX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [T_W-1:0]            tssc_i,
  input  logic [NS_W-1:0]           nssc_i,
  input  logic                      center_i,
  input  logic                      zero_off_i,
  input  logic [TBL_D*SAMP_W-1:0]   table_i,
  output logic                      wrap_o,
  output logic                      first_o,
  output logic signed [SAMP_W:0]    sample_o
);
  localparam logic [SAMP_W-1:0] MAG_CAP = SAMP_W'(2 ** FRAC_W - 1);

  logic [T_W:0]       t_q, t_top;
  logic [IDX_W-1:0]   i_q, s_cnt, idx;
  logic [1:0]         q_q;
  logic               t_last, s_last, neg;
  logic [SAMP_W-1:0]  mag_raw, mag;

  assign t_top  = {1'b0, tssc_i} + 1'b1;
  assign s_cnt  = (nssc_i == '0) ? IDX_W'(2) : {nssc_i, 1'b0};
  assign t_last = (t_q == t_top);
  assign s_last = (i_q == s_cnt - 1'b1);
  assign wrap_o = t_last && s_last && (q_q == 2'd3);
  assign first_o = (t_q == '0) && (i_q == '0) && (q_q == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
      i_q <= '0;
      q_q <= '0;
    end else if (t_last) begin
      t_q <= '0;
      if (s_last) begin
        i_q <= '0;
        q_q <= q_q + 1'b1;
      end else begin
        i_q <= i_q + 1'b1;
      end
    end else begin
      t_q <= t_q + 1'b1;
    end
  end

  // odd quarters walk the table back down
  assign idx     = q_q[0] ? (s_cnt - 1'b1 - i_q) : i_q;
  assign mag_raw = table_i[int'(idx)*SAMP_W +: SAMP_W];
  assign mag     = (zero_off_i && mag_raw > MAG_CAP) ? MAG_CAP : mag_raw;
  assign neg     = center_i ? q_q[1] : 1'b1;
  assign sample_o = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  // R4
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_q <= t_top) && (i_q < s_cnt));
  // R4
  wrap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> first_o);
endmodule

// File: rtl/ssc_sd_accum.sv
module ssc_sd_accum
  import ssc_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int SAMP_W = 7,
  parameter int DIV_W  = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  mode_e                  mode_i,
  input  logic [DIV_W-1:0]       m_i,
  input  logic [FRAC_W-1:0]      offset_i,
  input  logic signed [SAMP_W:0] sample_i,
  input  logic                   first_i,
  output logic [DIV_W-1:0]       div_o,
  output logic                   err_o
);
  localparam int SUM_W = SAMP_W + 4;

  logic [FRAC_W-1:0]        acc_q, acc_use;
  logic signed [SUM_W-1:0]  inc, sum, carry;
  logic [DIV_W-1:0]         div_q;
  logic                     err_q;

  assign acc_use = first_i ? '0 : acc_q;

  always_comb begin
    unique case (mode_i)
      MODE_SSC:  inc = SUM_W'($signed({1'b0, offset_i})) + SUM_W'(sample_i);
      MODE_FRAC: inc = SUM_W'($signed({1'b0, offset_i}));
      default:   inc = '0;
    endcase
  end

  assign sum   = SUM_W'($signed({1'b0, acc_use})) + inc;
  assign carry = sum >>> FRAC_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      div_q <= '0;
      err_q <= 1'b0;
    end else begin
      acc_q <= sum[FRAC_W-1:0];
      div_q <= m_i + DIV_W'(carry);
      err_q <= (mode_i == MODE_BAD);
    end
  end

  assign div_o = div_q;
  assign err_o = err_q;

  // R2
  frac_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FRAC) |=> (div_o == $past(m_i) || div_o == $past(m_i) + 1'b1));
  // R3
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BAD) |=> (err_o && div_o == $past(m_i)));
  // R10
  acc_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_i && mode_i == MODE_FRAC) |=> (div_o == $past(m_i)));
endmodule

// File: rtl/ssc_frac_div.sv
module ssc_frac_div
  import ssc_pkg::*;
#(
  parameter int N_W    = 12,
  parameter int A_W    = 4,
  parameter int FRAC_W = 6,
  parameter int T_W    = 4,
  parameter int NS_W   = 4,
  parameter int SAMP_W = 7,
  parameter int DIV_W  = N_W + 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                load_i,
  input  logic [N_W-1:0]                      n_i,
  input  logic [A_W-1:0]                      a_i,
  input  logic [FRAC_W-1:0]                   offset_i,
  input  logic [T_W-1:0]                      tssc_i,
  input  logic [NS_W-1:0]                     nssc_i,
  input  logic                                sd_en_i,
  input  logic                                center_i,
  input  logic [(2**(NS_W+1))*SAMP_W-1:0]     table_i,
  output logic [DIV_W-1:0]                    div_o,
  output logic                                err_o,
  output logic                                period_start_o
);
  localparam int TBL_W = (2 ** (NS_W + 1)) * SAMP_W;

  typedef struct packed {
    logic [TBL_W-1:0]  tbl;
    logic              center;
    logic              sd_en;
    logic [NS_W-1:0]   nssc;
    logic [T_W-1:0]    tssc;
    logic [FRAC_W-1:0] off;
    logic [A_W-1:0]    a;
    logic [N_W-1:0]    n;
  } cfg_t;

  cfg_t                   cfg_in, act;
  logic                   wrap, first, start_q;
  logic signed [SAMP_W:0] sample;
  logic [DIV_W-1:0]       m_int;
  mode_e                  mode;

  assign cfg_in = '{tbl: table_i, center: center_i, sd_en: sd_en_i, nssc: nssc_i,
                    tssc: tssc_i, off: offset_i, a: a_i, n: n_i};

  ssc_cfg_regs #(.CFG_W($bits(cfg_t))) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .wrap_i (wrap),
    .cfg_i  (cfg_in),
    .act_o  (act)
  );

  assign m_int = DIV_W'({act.n, 1'b0}) + DIV_W'(act.a) + DIV_W'(1);
  assign mode  = pick_mode(act.tssc != '0, act.sd_en, act.off != '0);

  ssc_profile_seq #(.T_W(T_W), .NS_W(NS_W), .SAMP_W(SAMP_W), .FRAC_W(FRAC_W)) u_prof (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tssc_i     (act.tssc),
    .nssc_i     (act.nssc),
    .center_i   (act.center),
    .zero_off_i (act.off == '0),
    .table_i    (act.tbl),
    .wrap_o     (wrap),
    .first_o    (first),
    .sample_o   (sample)
  );

  ssc_sd_accum #(.FRAC_W(FRAC_W), .SAMP_W(SAMP_W), .DIV_W(DIV_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .m_i      (m_int),
    .offset_i (act.off),
    .sample_i (sample),
    .first_i  (first),
    .div_o    (div_o),
    .err_o    (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= first;
  end
  assign period_start_o = start_q;

  // R7
  clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SSC && act.off == '0) |-> (sample <= 63 && sample >= -63));
  // R1
  int_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_INT) |=> (div_o == $past(m_int) && !err_o));
endmodule

// File: tb/ssc_frac_div_tb.sv
`timescale 1ns/1ps
module ssc_frac_div_tb;
  localparam int SAMP_W = 7;
  localparam int TBL_D  = 32;

  typedef struct {
    int n, a, off, tssc, nssc, sd, center, seed;
  } cfg_t;

  typedef struct {
    int     id;
    longint total;
    int     len;
    bit     err;
    longint lo, hi;
    string  tag;
  } item_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, load_i = 1'b0;
  logic [11:0] n_i = '0;
  logic [3:0]  a_i = '0, tssc_i = '0, nssc_i = '0;
  logic [5:0]  offset_i = '0;
  logic        sd_en_i = 1'b0, center_i = 1'b0;
  logic [TBL_D*SAMP_W-1:0] table_i = '0;
  logic [13:0] div_o;
  logic        err_o, period_start_o;

  int n_chk = 0, n_fail = 0;
  int per_cnt = 0;
  longint sum_acc, mn, mx;
  int len_acc;
  bit err_first;
  item_t sb[$];

  always #2.5 clk_i = ~clk_i;

  ssc_frac_div u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .n_i(n_i), .a_i(a_i),
    .offset_i(offset_i), .tssc_i(tssc_i), .nssc_i(nssc_i), .sd_en_i(sd_en_i),
    .center_i(center_i), .table_i(table_i), .div_o(div_o), .err_o(err_o),
    .period_start_o(period_start_o)
  );

  function automatic int tbl_val(int seed, int i);
    return (i * 37 + seed * 11 + 3) % 128;
  endfunction

  function automatic logic [TBL_D*SAMP_W-1:0] mk_tbl(int seed);
    logic [TBL_D*SAMP_W-1:0] t;
    for (int i = 0; i < TBL_D; i++) t[i*SAMP_W +: SAMP_W] = SAMP_W'(tbl_val(seed, i));
    return t;
  endfunction

  function automatic longint fdiv64(longint x);
    if (x >= 0) return x / 64;
    return -((-x + 63) / 64);
  endfunction

  function automatic item_t model(cfg_t c, int id, string tag);
    item_t it;
    longint m, p, inc, ssum;
    int s, t;
    m = 2 * c.n + c.a + 1;
    s = 2 * ((c.nssc == 0) ? 1 : c.nssc);
    t = c.tssc + 2;
    p = 4 * s * t;
    it.id = id; it.len = int'(p); it.tag = tag; it.err = 0;
    it.lo = m; it.hi = m;
    if (c.tssc == 0) inc = 0;
    else if (c.sd == 0 && c.off == 0) begin inc = 0; it.err = 1; end
    else if (c.sd == 0) begin inc = c.off * p; it.hi = m + 1; end
    else begin
      ssum = 0;
      if (!c.center)
        for (int i = 0; i < s; i++) begin
          int v;
          v = tbl_val(c.seed, i);
          if (c.off == 0 && v > 63) v = 63;
          ssum -= 4 * t * v;
        end
      inc = c.off * p + ssum;
      it.lo = 0; it.hi = 64'h7fff_ffff;
    end
    it.total = m * p + fdiv64(inc);
    return it;
  endfunction

  task automatic check(bit ok, string req, string what, longint got, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic close_period(int id);
    item_t it;
    if (sb.size() == 0 || sb[0].id != id) return;
    it = sb.pop_front();
    check(sum_acc == it.total, it.tag, $sformatf("period %0d total", id), sum_acc, it.total);
    check(len_acc == it.len, "R4", $sformatf("period %0d length", id), len_acc, it.len);
    check(err_first == it.err, it.tag, $sformatf("period %0d err", id), err_first, it.err);
    check(mn >= it.lo && mx <= it.hi, it.tag, $sformatf("period %0d max div", id), mx, it.hi);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (period_start_o) begin
        if (per_cnt > 0) close_period(per_cnt - 1);
        per_cnt++;
        sum_acc = div_o; len_acc = 1; mn = div_o; mx = div_o; err_first = err_o;
      end else if (per_cnt > 0) begin
        sum_acc += div_o; len_acc++;
        if (div_o < mn) mn = div_o;
        if (div_o > mx) mx = div_o;
      end
    end
  end

  int want = 0;

  // driver: load during period 'want', expect new settings in the following one
  task automatic apply(cfg_t c, string tag);
    forever begin
      @(negedge clk_i); #1;
      if (period_start_o && per_cnt - 1 == want) break;
    end
    sb.push_back(model(c, want + 1, tag));
    n_i = 12'(c.n); a_i = 4'(c.a); offset_i = 6'(c.off); tssc_i = 4'(c.tssc);
    nssc_i = 4'(c.nssc); sd_en_i = 1'(c.sd); center_i = 1'(c.center);
    table_i = mk_tbl(c.seed);
    load_i = 1'b1;
    @(negedge clk_i); #1;
    load_i = 1'b0;
    // R8: scrambled inputs without a load must not matter
    n_i = 12'h5a5; a_i = 4'hf; offset_i = 6'h2b; tssc_i = 4'h0; nssc_i = 4'h9;
    sd_en_i = 1'b1; center_i = ~center_i; table_i = mk_tbl(c.seed + 7);
    want = want + 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cfg_t z;
    z = '{default: 0};
    repeat (3) begin
      @(negedge clk_i);
      check(div_o == 0 && err_o == 0 && period_start_o == 0, "R9", "reset outputs",
            {div_o, err_o, period_start_o}, 0);
    end
    rst_ni = 1'b1;
    sb.push_back(model(z, 0, "R9"));
    apply('{n:10,   a:3,  off:0,  tssc:0,  nssc:2, sd:0, center:0, seed:1}, "R1");
    apply('{n:7,    a:2,  off:30, tssc:0,  nssc:1, sd:1, center:1, seed:2}, "R1");
    apply('{n:22,   a:3,  off:20, tssc:3,  nssc:2, sd:0, center:0, seed:3}, "R2");
    apply('{n:22,   a:3,  off:0,  tssc:2,  nssc:3, sd:0, center:0, seed:4}, "R3");
    apply('{n:22,   a:3,  off:0,  tssc:14, nssc:6, sd:1, center:1, seed:5}, "R5");
    apply('{n:30,   a:1,  off:37, tssc:1,  nssc:3, sd:1, center:1, seed:6}, "R5");
    apply('{n:40,   a:5,  off:0,  tssc:2,  nssc:5, sd:1, center:0, seed:9}, "R7");
    apply('{n:40,   a:5,  off:9,  tssc:1,  nssc:4, sd:1, center:0, seed:9}, "R6");
    apply('{n:12,   a:0,  off:1,  tssc:5,  nssc:0, sd:0, center:0, seed:0}, "R10");
    apply('{n:4095, a:15, off:0,  tssc:0,  nssc:1, sd:0, center:0, seed:0}, "R1");
    apply('{n:3,    a:1,  off:63, tssc:1,  nssc:1, sd:0, center:0, seed:0}, "R2");
    while (sb.size() != 0) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule